// File: doc/BRIEF.md
# Oversampled Serial Receiver with Frame-End Enable Gating

This block receives asynchronous serial frames on a single line. The line is resynchronised, and each bit is sampled near its middle, using a tick that runs at sixteen times the bit rate. The shift register always follows the line and assembles every frame, whatever the receive enable says.

The enable is looked at only once per frame, on the clock cycle that samples the stop bit. If the enable is high in that cycle, the block copies the assembled word into the data register, updates the ready and error flags, and can raise its interrupt requests. If the enable is low in that cycle, the frame is dropped without leaving any trace. As a result, an enable that arrives late in a frame still captures that frame, and an enable that is removed mid-frame loses it.

Two debug inputs can halt the receiver. In the first mode it freezes at once, wherever it is in the frame. In the second mode it finishes the frame in progress and then holds.

Top module: `serial_rx_gated`

## Requirements
- R1: Frame format and sampling.
  - The line idles high. A frame is one low start bit, then DATA_W data bits least significant bit first, then one parity bit when `par_en`=1, then one stop bit.
  - Each bit lasts OS ticks and is sampled on the 8th tick of that bit.
  - A frame that is transferred appears on `rd_data`, and `st_ready` is 1 from the cycle after the stop sample.
- R2: A start is confirmed only if the line is still low at the start bit's 8th tick. A low pulse shorter than that is ignored and produces no word.
- R3: With `rx_en`=0 on the stop-sample cycle, the frame is dropped: `rd_data`, `st_ready`, `st_ovr`, `st_frm` and `st_par` keep their values.
- R4: `irq_rx` = `st_ready` AND `rx_en`. `irq_err` = (`st_ovr` OR `st_frm` OR `st_par`) AND `rx_en`. Both are 0 whenever `rx_en`=0, even if flags are set.
- R5: If `rx_en` rises partway through a frame, before the stop sample, that frame's word is transferred intact, because the shift register kept assembling it.
- R6: If `rx_en` falls partway through a frame, before the stop sample, that frame is not transferred.
- R7: A stop bit sampled as 0 sets `st_frm` on transfer, and the word is still loaded.
- R8: With `par_en`=1, the expected parity bit makes the count of ones over the data bits and the parity bit even (`par_odd`=0) or odd (`par_odd`=1). A mismatch sets `st_par` on transfer.
- R9: A transfer while `st_ready`=1 and `rd_strobe`=0 sets `st_ovr`, and the new word replaces the old one.
- R10: Reads.
  - `rd_strobe` clears `st_ready`, `st_ovr`, `st_frm` and `st_par` on the next edge.
  - When a read and a transfer share a cycle, the new word is loaded, `st_ready` stays 1, `st_ovr` stays 0, and the error flags take that frame's values.
- R11: With `dbg_halt`=1 and `dbg_cont`=0, the receiver freezes mid-frame and ignores ticks. On release it resumes at the same point and receives the word correctly.
- R12: With `dbg_halt`=1 and `dbg_cont`=1, the frame in progress completes and is transferred. The receiver then stays idle and ignores new frames until `dbg_halt` falls.
- R13: After reset, `rd_data` is 0, and all flags and interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input, idle high |
| baud_tick | input | 1 | One-cycle pulse at OS times the bit rate |
| rx_en | input | 1 | Receive enable, decided at the stop sample |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| dbg_halt | input | 1 | Debug suspend request |
| dbg_cont | input | 1 | 1 lets the current frame finish under suspend |
| rd_strobe | input | 1 | Read of the data register; clears the flags |
| rd_data | output | DATA_W | Received data register |
| st_ready | output | 1 | Unread word present |
| st_ovr | output | 1 | Overrun flag |
| st_frm | output | 1 | Framing error flag |
| st_par | output | 1 | Parity error flag |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
A read of the data register and the transfer of a new frame can land on the same clock cycle. The outcome then depends on how the clear and the load are ordered.

The bench provokes this case by counting ticks so that `rd_strobe` is asserted exactly on the tick that samples the stop bit, while an earlier word is still unread. It then expects the new word on `rd_data` with ready still set and no overrun.

Random frames that either read just before the next frame or leave the word unread exercise the plain overrun path against the bench's own model of the flags.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int MAX_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

  // parity bit that makes the total count even (odd=0) or odd (odd=1)
  function automatic logic par_bit(input logic [MAX_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  output logic y
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], a};
  end

  assign y = chain[STAGES-1];
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OS     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_s,
  input  logic              tick,
  input  logic              run,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              done,
  output logic [DATA_W-1:0] word,
  output logic              fe,
  output logic              pe,
  output logic              idle,
  output rx_state_e         state_o
);
  localparam int CW = $clog2(OS);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] CNT_MID  = CW'(OS / 2 - 2);
  localparam logic [CW-1:0] CNT_END  = CW'(OS - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bidx;
  logic [DATA_W-1:0] shreg;
  logic              pe_r;
  logic              step;
  logic              at_end;

  assign step   = run & tick;
  assign at_end = (cnt == CNT_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      shreg <= '0;
      pe_r  <= 1'b0;
    end else if (step) begin
      case (state)
        ST_IDLE: begin
          if (!rx_s) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end
        ST_START: begin
          if (cnt == CNT_MID) begin
            cnt <= '0;
            if (!rx_s) begin
              state <= ST_DATA;
              bidx  <= '0;
              pe_r  <= 1'b0;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (at_end) begin
            cnt   <= '0;
            shreg <= {rx_s, shreg[DATA_W-1:1]};
            if (bidx == BIT_LAST) state <= par_en ? ST_PAR : ST_STOP;
            else                  bidx  <= bidx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (at_end) begin
            cnt   <= '0;
            pe_r  <= rx_s ^ par_bit(MAX_W'(shreg), par_odd);
            state <= ST_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (at_end) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done    = step && (state == ST_STOP) && at_end;
  assign word    = shreg;
  assign fe      = ~rx_s;
  assign pe      = pe_r;
  assign idle    = (state == ST_IDLE);
  assign state_o = state;
endmodule

// File: rtl/srx_regs.sv
module srx_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic [DATA_W-1:0] word,
  input  logic              fe,
  input  logic              pe,
  input  logic              rd,
  output logic [DATA_W-1:0] data,
  output logic              ready,
  output logic              ovr,
  output logic              frm,
  output logic              par
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      ready <= 1'b0;
      ovr   <= 1'b0;
      frm   <= 1'b0;
      par   <= 1'b0;
    end else if (xfer) begin
      data  <= word;
      ready <= 1'b1;
      if (rd) begin
        ovr <= 1'b0;
        frm <= fe;
        par <= pe;
      end else begin
        ovr <= ovr | ready;
        frm <= frm | fe;
        par <= par | pe;
      end
    end else if (rd) begin
      ready <= 1'b0;
      ovr   <= 1'b0;
      frm   <= 1'b0;
      par   <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_gated.sv
module serial_rx_gated
  import srx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OS          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              baud_tick,
  input  logic              rx_en,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              dbg_halt,
  input  logic              dbg_cont,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data,
  output logic              st_ready,
  output logic              st_ovr,
  output logic              st_frm,
  output logic              st_par,
  output logic              irq_rx,
  output logic              irq_err
);
  logic              rx_s;
  logic              evt_done;
  logic              evt_xfer;
  logic              frozen;
  logic              shf_idle;
  logic              shf_fe;
  logic              shf_pe;
  logic [DATA_W-1:0] shf_word;
  rx_state_e         shf_state;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .a(rx_line), .y(rx_s)
  );

  // halt now, or let the current frame finish and hold once idle
  assign frozen = dbg_halt & (~dbg_cont | shf_idle);

  srx_shifter #(.DATA_W(DATA_W), .OS(OS)) u_shf (
    .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .tick(baud_tick), .run(~frozen),
    .par_en(par_en), .par_odd(par_odd), .done(evt_done), .word(shf_word),
    .fe(shf_fe), .pe(shf_pe), .idle(shf_idle), .state_o(shf_state)
  );

  // enable is judged only on the stop-sample cycle
  assign evt_xfer = evt_done & rx_en;

  srx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .xfer(evt_xfer), .word(shf_word),
    .fe(shf_fe), .pe(shf_pe), .rd(rd_strobe), .data(rd_data),
    .ready(st_ready), .ovr(st_ovr), .frm(st_frm), .par(st_par)
  );

  assign irq_rx  = st_ready & rx_en;
  assign irq_err = (st_ovr | st_frm | st_par) & rx_en;
endmodule

// File: rtl/srx_chk.sv
module srx_chk
  import srx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              rd_strobe,
  input logic              dbg_halt,
  input logic              dbg_cont,
  input logic              evt_done,
  input logic              evt_xfer,
  input logic              frozen,
  input logic              shf_idle,
  input rx_state_e         shf_state,
  input logic [DATA_W-1:0] rd_data,
  input logic              st_ready,
  input logic              st_ovr,
  input logic              st_frm,
  input logic              st_par,
  input logic              irq_rx,
  input logic              irq_err
);
  a_r1_ready_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    evt_xfer |=> st_ready);

  a_r3_drop_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_done && !rx_en && !rd_strobe) |=>
      $stable({rd_data, st_ready, st_ovr, st_frm, st_par}));

  a_r4_irq_silent_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> (!irq_rx && !irq_err));

  a_r9_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_xfer && st_ready && !rd_strobe) |=> (st_ovr && st_ready));

  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !evt_xfer) |=> (!st_ready && !st_ovr && !st_frm && !st_par));

  a_r10_read_and_load: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && evt_xfer) |=> (st_ready && !st_ovr));

  a_r11_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(shf_state));

  a_r11_no_done_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> !evt_done);

  a_r12_cont_finishes: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && dbg_cont && !shf_idle) |-> !frozen);
endmodule

bind serial_rx_gated srx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_strobe(rd_strobe),
  .dbg_halt(dbg_halt), .dbg_cont(dbg_cont), .evt_done(evt_done),
  .evt_xfer(evt_xfer), .frozen(frozen), .shf_idle(shf_idle),
  .shf_state(shf_state), .rd_data(rd_data), .st_ready(st_ready),
  .st_ovr(st_ovr), .st_frm(st_frm), .st_par(st_par),
  .irq_rx(irq_rx), .irq_err(irq_err)
);

// File: tb/tb_serial_rx_gated.sv
`timescale 1ns/1ps
module tb_serial_rx_gated;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_line = 1'b1, baud_tick = 1'b0, rx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic dbg_halt = 1'b0, dbg_cont = 1'b0, rd_strobe = 1'b0;
  logic [DW-1:0] rd_data;
  logic st_ready, st_ovr, st_frm, st_par, irq_rx, irq_err;

  always #2 clk = ~clk;  // 250 MHz

  serial_rx_gated #(.DATA_W(DW), .OS(16), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_tick(baud_tick),
    .rx_en(rx_en), .par_en(par_en), .par_odd(par_odd), .dbg_halt(dbg_halt),
    .dbg_cont(dbg_cont), .rd_strobe(rd_strobe), .rd_data(rd_data),
    .st_ready(st_ready), .st_ovr(st_ovr), .st_frm(st_frm), .st_par(st_par),
    .irq_rx(irq_rx), .irq_err(irq_err)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // bench model of the register side
  logic [DW-1:0] m_data = '0;
  logic m_rdy = 0, m_ovr = 0, m_frm = 0, m_par = 0;

  function automatic logic tx_parity(input logic [DW-1:0] d, input logic odd);
    int ones = 0;
    for (int i = 0; i < DW; i++) if (d[i]) ones++;
    return ((ones % 2) == 1) ^ odd;
  endfunction

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (3) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  endtask

  task automatic check_state(input string tag);
    logic [DW+5:0] act, exp;
    act = {rd_data, st_ready, st_ovr, st_frm, st_par, irq_rx, irq_err};
    exp = {m_data, m_rdy, m_ovr, m_frm, m_par, m_rdy & rx_en, (m_ovr | m_frm | m_par) & rx_en};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_read();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
    m_rdy = 0; m_ovr = 0; m_frm = 0; m_par = 0;
  endtask

  // en_mode: 0 keep, 1 raise enable at bit 3, 2 drop enable at bit 3
  // halt_bit: frame position where dbg_halt rises at tick 4 (-1 none);
  // halt_ticks 0 leaves it raised
  task automatic send_frame(input logic [DW-1:0] d, input bit bad_par, input bit bad_stop,
                            input int en_mode, input bit rd_at_stop, input int halt_bit,
                            input int halt_ticks, input bit ignored);
    logic bits [0:11];
    int nb, k;
    bit xfer;
    logic fe_e, pe_e;
    bits[0] = 1'b0;
    for (int i = 0; i < DW; i++) bits[1+i] = d[i];
    nb = DW + 1;
    if (par_en) begin
      bits[nb] = tx_parity(d, par_odd) ^ bad_par;
      nb++;
    end
    bits[nb] = ~bad_stop;
    nb++;
    for (k = 0; k < nb; k++) begin
      rx_line = bits[k];
      if (k == 3 && en_mode == 1) rx_en = 1'b1;
      if (k == 3 && en_mode == 2) rx_en = 1'b0;
      if (k == halt_bit) begin
        tick_n(4);
        dbg_halt = 1'b1;
        if (halt_ticks > 0) begin
          tick_n(halt_ticks);
          dbg_halt = 1'b0;
        end
        tick_n(12);
      end else if (k == nb - 1) begin
        tick_n(7);
        repeat (3) @(negedge clk);
        baud_tick = 1'b1;
        rd_strobe = rd_at_stop;
        @(negedge clk);
        baud_tick = 1'b0;
        rd_strobe = 1'b0;
        rx_line = 1'b1;
        tick_n(8);
      end else begin
        tick_n(16);
      end
    end
    rx_line = 1'b1;
    tick_n(2);
    fe_e = bad_stop;
    pe_e = par_en & bad_par;
    xfer = !ignored && rx_en;
    if (xfer) begin
      if (rd_at_stop) begin
        m_ovr = 0; m_frm = fe_e; m_par = pe_e;
      end else begin
        m_ovr = m_ovr | m_rdy; m_frm = m_frm | fe_e; m_par = m_par | pe_e;
      end
      m_rdy = 1; m_data = d;
    end else if (rd_at_stop) begin
      m_rdy = 0; m_ovr = 0; m_frm = 0; m_par = 0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    tick_n(2);
    check_state("R13 reset state");

    rx_en = 1'b1;
    send_frame(8'h5A, 0, 0, 0, 0, -1, 0, 0);
    check_state("R1 basic frame");
    check_state("R4 irq with enable");
    do_read();
    check_state("R10 read clears ready");

    rx_line = 1'b0; tick_n(3); rx_line = 1'b1; tick_n(40);
    check_state("R2 short low pulse ignored");

    rx_en = 1'b0;
    send_frame(8'h3C, 0, 0, 0, 0, -1, 0, 0);
    check_state("R3 disabled frame dropped");

    rx_en = 1'b1;
    send_frame(8'h11, 0, 0, 0, 0, -1, 0, 0);
    @(negedge clk); rx_en = 1'b0; @(negedge clk);
    check_state("R4 irq masked while disabled");
    rx_en = 1'b1;
    do_read();

    rx_en = 1'b0;
    send_frame(8'hC3, 0, 0, 1, 0, -1, 0, 0);
    check_state("R5 late enable captures frame");
    do_read();

    rx_en = 1'b1;
    send_frame(8'h96, 0, 0, 2, 0, -1, 0, 0);
    check_state("R6 early disable drops frame");
    rx_en = 1'b1;

    send_frame(8'h7E, 0, 1, 0, 0, -1, 0, 0);
    check_state("R7 framing error flagged");
    do_read();
    check_state("R10 read clears framing flag");

    par_en = 1'b1; par_odd = 1'b0;
    send_frame(8'hB1, 0, 0, 0, 0, -1, 0, 0);
    check_state("R8 even parity good");
    do_read();
    send_frame(8'hB1, 1, 0, 0, 0, -1, 0, 0);
    check_state("R8 even parity bad");
    do_read();
    par_odd = 1'b1;
    send_frame(8'h0F, 0, 0, 0, 0, -1, 0, 0);
    check_state("R8 odd parity good");
    send_frame(8'h0E, 1, 0, 0, 0, -1, 0, 0);
    check_state("R8 odd parity bad with overrun");
    do_read();
    par_en = 1'b0;

    send_frame(8'h21, 0, 0, 0, 0, -1, 0, 0);
    send_frame(8'h42, 0, 0, 0, 0, -1, 0, 0);
    check_state("R9 overrun replaces word");
    do_read();

    send_frame(8'h33, 0, 0, 0, 0, -1, 0, 0);
    send_frame(8'hE4, 0, 0, 0, 1, -1, 0, 0);
    check_state("R10 read and load same cycle");
    do_read();

    dbg_cont = 1'b0;
    send_frame(8'hA5, 0, 0, 0, 0, 3, 20, 0);
    check_state("R11 freeze and resume");
    do_read();

    dbg_cont = 1'b1;
    send_frame(8'h6B, 0, 0, 0, 0, 5, 0, 0);
    check_state("R12 frame completes under suspend");
    do_read();
    send_frame(8'h19, 0, 0, 0, 0, -1, 0, 1);
    check_state("R12 halted after frame");
    dbg_halt = 1'b0; dbg_cont = 1'b0;
    tick_n(4);

    for (int n = 0; n < 40; n++) begin
      logic [DW-1:0] d;
      int mode;
      d = DW'($urandom);
      par_en = $urandom_range(0, 1);
      par_odd = $urandom_range(0, 1);
      rx_en = ($urandom_range(0, 4) != 0);
      mode = ($urandom_range(0, 5) == 0) ? $urandom_range(1, 2) : 0;
      if ($urandom_range(0, 1) == 1) do_read();
      send_frame(d, $urandom_range(0, 5) == 0, $urandom_range(0, 6) == 0, mode,
                 rx_en && ($urandom_range(0, 7) == 0), -1, 0, 0);
      check_state("R1 R9 random frame");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule